// File: doc/BRIEF.md
# Adjacent-Transition Code Checker

This block watches a data word that travels together with a small set of check bits, and reports whether the two still agree. The check code records where neighbouring data bits differ. Adjacent bits form overlapping pairs, starting at the least significant end, and each pair is weighted by a rising power of two. The weighted sum of the pair transitions is carried on one check bit per pair, so each check bit is the XOR of two neighbouring data bits. For a data width of `DATA_W` there are `DATA_W-1` check bits. The code misses exactly one data corruption: every data bit inverted at once. That pattern leaves every transition unchanged.

The checker rebuilds the check bits from the arriving data and compares them with the received check bits. It reports the result on a two-rail pair, so that an output stuck at a constant can itself be seen. A parameter picks an optional input register stage. The output pair is always registered. A data width below 2 stops elaboration.

Top module: `trans_code_checker`

## Requirements
- R1: While `rst` is high, `err_pair` reads exactly 2'b01 from the first clock edge onward.
- R2: Check bit i is `data_in[i] XOR data_in[i+1]`, for i from 0 to DATA_W-2. When every received check bit equals its rebuilt value, `err_pair` is a valid code: the two rails differ (01 or 10).
- R3: When any received check bit differs from its rebuilt value, `err_pair` is an error code: the two rails are equal (00 or 11).
- R4: Take a word and its correct check bits, and corrupt only the data by an XOR pattern. Every non-zero pattern raises the error code, except the pattern that inverts all data bits, which yields a valid code.
- R5: A correct data word sent with any non-zero corruption of the check bits alone raises the error code.
- R6: With `REG_IN`=1 the result for inputs sampled at clock edge n appears on `err_pair` after edge n+1. With `REG_IN`=0 it appears after edge n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | DATA_W | Protected data word |
| check_in | input | DATA_W-1 | Received transition check bits |
| err_pair | output | 2 | Two-rail result: 01/10 valid, 00/11 error |

## Verification
The bench runs every data-corruption pattern against every data word at width 8 and width 4. A design that mishandled the all-inverted pattern would either flag it wrongly or miss multi-bit patterns that leave most transitions unchanged. It sweeps every non-zero check-only corruption, so a comparator tree that dropped a leaf or an edge pair would show a valid code where an error is due. Isolated error pulses between valid words pin the cycle on which the result lands for both register options, which exposes a missing or an extra stage.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  typedef logic [1:0] rail_pair_t;
  // valid code driven while the block is held in reset
  localparam rail_pair_t RAIL_IDLE = 2'b01;
endpackage

// File: rtl/tcc_in_stage.sv
module tcc_in_stage #(
  parameter int DATA_W = 8,
  localparam int CHK_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] data_d,
  input  logic [CHK_W-1:0]  chk_d,
  output logic [DATA_W-1:0] data_q,
  output logic [CHK_W-1:0]  chk_q
);
  // zero data with zero check bits is itself a code word
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      chk_q  <= '0;
    end else begin
      data_q <= data_d;
      chk_q  <= chk_d;
    end
  end
endmodule

// File: rtl/tcc_regen.sv
module tcc_regen #(
  parameter int DATA_W = 8,
  localparam int CHK_W = DATA_W - 1
) (
  input  logic [DATA_W-1:0] data,
  output logic [CHK_W-1:0]  chk
);
  // one check bit per overlapping neighbour pair, lowest pair first
  for (genvar i = 0; i < CHK_W; i++) begin : g_pair
    assign chk[i] = data[i] ^ data[i+1];
  end
endmodule

// File: rtl/tcc_tworail_tree.sv
module tcc_tworail_tree #(
  parameter int LEAVES = 7,
  localparam int NODES = 2 * LEAVES - 1
) (
  input  logic [LEAVES-1:0] rebuilt,
  input  logic [LEAVES-1:0] received,
  output logic              rail_t,
  output logic              rail_f
);
  // heap-ordered binary tree: leaves sit at LEAVES-1 .. NODES-1,
  // node n merges nodes 2n+1 and 2n+2, root is node 0
  always_comb begin
    logic [NODES-1:0] t;
    logic [NODES-1:0] f;
    t = '0;
    f = '0;
    for (int j = 0; j < LEAVES; j++) begin
      t[LEAVES-1+j] = rebuilt[j];
      f[LEAVES-1+j] = ~received[j];
    end
    for (int n = LEAVES - 2; n >= 0; n--) begin
      t[n] = (t[2*n+1] & t[2*n+2]) | (f[2*n+1] & f[2*n+2]);
      f[n] = (t[2*n+1] & f[2*n+2]) | (f[2*n+1] & t[2*n+2]);
    end
    rail_t = t[0];
    rail_f = f[0];
  end
endmodule

// File: rtl/trans_code_checker.sv
module trans_code_checker
  import tcc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter bit REG_IN = 1'b1,
  localparam int CHK_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] data_in,
  input  logic [CHK_W-1:0]  check_in,
  output logic [1:0]        err_pair
);
  if (DATA_W < 2) begin : g_bad_width
    $error("trans_code_checker: DATA_W must be at least 2");
  end

  logic [DATA_W-1:0] data_s;
  logic [CHK_W-1:0]  chk_s;
  logic [CHK_W-1:0]  chk_rebuilt;
  logic              root_t;
  logic              root_f;

  if (REG_IN) begin : g_in_reg
    tcc_in_stage #(.DATA_W(DATA_W)) u_in (
      .clk    (clk),
      .rst    (rst),
      .data_d (data_in),
      .chk_d  (check_in),
      .data_q (data_s),
      .chk_q  (chk_s)
    );
  end else begin : g_in_wire
    assign data_s = data_in;
    assign chk_s  = check_in;
  end

  tcc_regen #(.DATA_W(DATA_W)) u_regen (
    .data (data_s),
    .chk  (chk_rebuilt)
  );

  tcc_tworail_tree #(.LEAVES(CHK_W)) u_tree (
    .rebuilt  (chk_rebuilt),
    .received (chk_s),
    .rail_t   (root_t),
    .rail_f   (root_f)
  );

  always_ff @(posedge clk) begin
    if (rst) err_pair <= RAIL_IDLE;
    else     err_pair <= {root_t, root_f};
  end
endmodule

module tcc_props #(
  parameter int DATA_W = 8,
  parameter bit REG_IN = 1'b1,
  localparam int CHK_W = DATA_W - 1,
  localparam int LAT   = REG_IN ? 2 : 1
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] data_in,
  input logic [CHK_W-1:0]  check_in,
  input logic [1:0]        err_pair
);
  logic [1:0]       warm_cnt;
  logic [CHK_W-1:0] expect_chk;
  logic             mism;
  logic             one_off;
  logic             warm;

  assign expect_chk = CHK_W'(data_in ^ (data_in >> 1));
  assign mism       = (check_in != expect_chk);
  assign one_off    = ($countones(check_in ^ expect_chk) == 1);
  assign warm       = (warm_cnt >= 2'(LAT));

  always_ff @(posedge clk) begin
    if (rst)                   warm_cnt <= '0;
    else if (warm_cnt < 2'(LAT)) warm_cnt <= warm_cnt + 2'd1;
  end

  p_reset_idle_r1: assert property (@(posedge clk) rst |=> (err_pair == 2'b01));
  p_match_valid_r2: assert property (@(posedge clk) disable iff (rst)
    (warm && !$past(mism, LAT)) |-> (err_pair[1] != err_pair[0]));
  p_mismatch_error_r3: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(mism, LAT)) |-> (err_pair[1] == err_pair[0]));
  p_single_chk_flag_r5: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(one_off, LAT)) |-> (err_pair[1] == err_pair[0]));
endmodule

bind trans_code_checker tcc_props #(.DATA_W(DATA_W), .REG_IN(REG_IN)) u_props (
  .clk      (clk),
  .rst      (rst),
  .data_in  (data_in),
  .check_in (check_in),
  .err_pair (err_pair)
);

// File: tb/sim_trans_code_checker.sv
`timescale 1ns/1ps
module sim_trans_code_checker;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [7:0] d0 = '0;
  logic [6:0] c0 = '0;
  logic [1:0] e0;
  logic [3:0] d1 = '0;
  logic [2:0] c1 = '0;
  logic [1:0] e1;

  trans_code_checker #(.DATA_W(8), .REG_IN(1'b1)) u0 (
    .clk(clk), .rst(rst), .data_in(d0), .check_in(c0), .err_pair(e0));
  trans_code_checker #(.DATA_W(4), .REG_IN(1'b0)) u1 (
    .clk(clk), .rst(rst), .data_in(d1), .check_in(c1), .err_pair(e1));

  int checks = 0;
  int fails = 0;
  bit    q0[$];
  string t0[$];
  bit    q1[$];
  string t1[$];

  function automatic logic [6:0] model8(logic [7:0] d);
    logic [6:0] r;
    for (int i = 0; i < 7; i++) r[i] = (d[i] != d[i+1]);
    return r;
  endfunction

  function automatic logic [2:0] model4(logic [3:0] d);
    logic [2:0] r;
    for (int i = 0; i < 3; i++) r[i] = (d[i] != d[i+1]);
    return r;
  endfunction

  task automatic judge(string tag, string who, logic [1:0] got, bit exp_err);
    bit got_err;
    got_err = (got[1] == got[0]);
    checks++;
    if (got_err !== exp_err) begin
      fails++;
      $display("FAIL %s %s err_pair=%b error=%0b expected error=%0b",
               tag, who, got, got_err, exp_err);
    end
  endtask

  // drive one vector per cycle; compare each instance against its queue
  task automatic step(logic [7:0] a, logic [6:0] b, bit x0, string g0,
                      logic [3:0] p, logic [2:0] s, bit x1, string g1);
    @(negedge clk);
    if (q0.size() == 2) judge(t0.pop_front(), "u0", e0, q0.pop_front());
    if (q1.size() == 1) judge(t1.pop_front(), "u1", e1, q1.pop_front());
    d0 = a; c0 = b; d1 = p; c1 = s;
    q0.push_back(x0); t0.push_back(g0);
    q1.push_back(x1); t1.push_back(g1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    d0 = 8'hA5; c0 = 7'h13; d1 = 4'h9; c1 = 3'h5;
    repeat (3) @(negedge clk);
    checks++;
    if (e0 !== 2'b01) begin
      fails++;
      $display("FAIL R1 u0 err_pair=%b expected 01", e0);
    end
    checks++;
    if (e1 !== 2'b01) begin
      fails++;
      $display("FAIL R1 u1 err_pair=%b expected 01", e1);
    end
    q0.delete(); t0.delete(); q1.delete(); t1.delete();
    rst = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    do_reset();

    // R4: every data corruption pattern at both widths
    for (int d = 0; d < 256; d++) begin
      for (int e = 0; e < 256; e++) begin
        step(8'(d ^ e), model8(8'(d)), (e != 0 && e != 255), "R4",
             4'((d ^ e) & 15), model4(4'(d)),
             ((e & 15) != 0 && (e & 15) != 15), "R4/R6");
      end
    end

    // R5: correct data with every check-only corruption
    for (int d = 0; d < 256; d++) begin
      for (int c = 0; c < 128; c++) begin
        step(8'(d), model8(8'(d)) ^ 7'(c), (c != 0), "R5",
             4'(d), model4(4'(d)) ^ 3'(c), ((c & 7) != 0), "R5");
      end
    end

    // R2/R3: random words, check bits right about half the time
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] a;
      logic [6:0] b;
      logic [3:0] p;
      logic [2:0] s;
      a = 8'($urandom);
      p = 4'($urandom);
      b = ($urandom % 2 == 0) ? model8(a) : 7'($urandom);
      s = ($urandom % 2 == 0) ? model4(p) : 3'($urandom);
      step(a, b, (b != model8(a)), "R2/R3", p, s, (s != model4(p)), "R2/R3");
    end

    // R6: lone error pulses between code words pin the result cycle
    for (int n = 0; n < 6; n++) begin
      step(8'h3C, model8(8'h3C), 1'b0, "R6", 4'h6, model4(4'h6), 1'b0, "R6");
      step(8'h3C, model8(8'h3C) ^ 7'h40, 1'b1, "R6",
           4'h6, model4(4'h6) ^ 3'h4, 1'b1, "R6");
      step(8'hC3, model8(8'hC3), 1'b0, "R6", 4'h9, model4(4'h9), 1'b0, "R6");
    end

    // R1: reset again in the middle of traffic, then a short run
    do_reset();
    for (int n = 0; n < 8; n++) begin
      step(8'(n * 37), model8(8'(n * 37)), 1'b0, "R2",
           4'(n), model4(4'(n)) ^ 3'(n & 1), (n & 1) != 0, "R3");
    end

    // drain
    for (int n = 0; n < 3; n++)
      step(8'h00, 7'h00, 1'b0, "R2", 4'h0, 3'h0, 1'b0, "R2");

    summary();
    $finish;
  end
endmodule